// File: doc/BRIEF.md
# Temporal-Addressed Operand Belt

The block is an operand store that takes the place of a register file. Operands are named by their age: position 0 is the most recent result, position 1 the one before it, and so on. When a result is written, every older operand's position grows by one, and once more values have been written than the belt holds, the oldest ones can no longer be reached. No data is moved when a value is written. Each value sits in a storage cell tagged with the frame it belongs to and a per-frame sequence number. A read port turns a position into a sequence number and searches the cells for the matching tag.

Calls and returns nest up to a fixed depth. A call opens a fresh, empty frame and places its argument values at the front of that frame, so that argument 0 is at position 0. A return frees the callee's cells and resumes the caller with its own sequence count unchanged. The returned values are written at the front of the caller's frame. A read can only match cells that carry the tag of the frame currently running, so caller and callee never see each other's operands. The same write lanes carry results, call arguments and return values. In every case lane 0 ends at position 0.

Top module: `operand_belt`

## Requirements
- R1: After reset the frame depth is 0, and every read port reports invalid with zero data.
- R2: A single write makes its value position 0 and shifts every older value up by one. With BELT_LEN=8, once more than 8 values have been written, only the 8 newest can be read (positions 0 to 7).
- R3: When `drop_n` is 2, both lanes are written in one cycle. Lane 0 becomes position 0, lane 1 becomes position 1, and the previous position 0 moves to position 2.
- R4: A read of a position greater than or equal to the number of live values in the current frame sets its `rd_invalid` bit and returns zero data.
- R5: The four read ports are independent. Port i takes its position from `rd_pos[3i+2:3i]` and returns `rd_data[64i+63:64i]`, combinationally, from the state before the current cycle's writes. Writes become visible in the next cycle.
- R6: A call below the top depth raises `frame_depth` by one in the next cycle. The new frame holds exactly `drop_n` live values, with argument lane 0 at position 0. No caller value can be read from it.
- R7: A return lowers `frame_depth` by one. The caller's values reappear, shifted by the number of returned values, and the returned values sit at the front with lane 0 at position 0.
- R8: A call while `frame_depth` is 3 raises `call_overflow` in the same cycle and is ignored: the depth does not change and its arguments are not written anywhere.
- R9: A return while `frame_depth` is 0 is ignored: the depth stays 0 and its values are not written.
- R10: If `call_req` and `ret_req` are both high, the call is carried out and the return is ignored.
- R11: A new call made after a return sees only its own arguments. Nothing left by the earlier callee at that depth can be read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| drop_n | input | 2 | Number of write lanes used this cycle (0 to 2) |
| drop_data | input | 128 | Lane values, lane k at bits 64k+63:64k |
| call_req | input | 1 | Open a new frame; the lanes carry the arguments |
| ret_req | input | 1 | Close the current frame; the lanes carry the return values |
| rd_pos | input | 12 | Four 3-bit belt positions |
| rd_data | output | 256 | Four 64-bit operands |
| rd_invalid | output | 4 | Per-port flag for a position past the live values |
| frame_depth | output | 2 | Current frame nesting level |
| call_overflow | output | 1 | Call rejected because every frame is in use |

## Verification
The hardest situation to reach is a deep nest in which each frame holds a different number of live values, some of them saturated past the belt length, followed by returns that must expose the caller's older operands at shifted positions. Directed sequences first drive the belt past saturation, then nest to the top depth, try an overflow, and unwind with one and two return values. After that, random stimulus with a fixed seed mixes calls, returns and one- or two-lane writes so that the depth moves up and down many times. Every cycle, all four ports are compared against a per-frame shift model kept in the bench.

// File: rtl/belt_pkg.sv
// Shared types for the operand belt.
package belt_pkg;
    // Operation chosen for the current cycle by the frame controller.
    typedef enum logic [1:0] {
        OP_DROP = 2'd0,
        OP_CALL = 2'd1,
        OP_RET  = 2'd2,
        OP_IDLE = 2'd3
    } belt_op_e;
endpackage

// File: rtl/belt_frame_ctrl.sv
// Frame controller: tracks nesting depth and, per frame, a drop sequence
// counter and a saturating live count. Decides where this cycle's lanes are
// written (which frame and from which sequence number).
// Assumes MAXD >= 2 and that a call and a return are never both honoured.
module belt_frame_ctrl
    import belt_pkg::*;
#(
    parameter int BELT_LEN = 8,
    parameter int MAXD     = 4,
    parameter int DP       = 2,
    parameter int SEQ_W    = 8,
    localparam int FW      = $clog2(MAXD),
    localparam int LCW     = $clog2(BELT_LEN + 1),
    localparam int DNW     = $clog2(DP + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DNW-1:0]   drop_n,
    input  logic             call_req,
    input  logic             ret_req,
    output logic [FW-1:0]    depth,
    output logic [SEQ_W-1:0] cur_seq,
    output logic [LCW-1:0]   cur_live,
    output logic [FW-1:0]    wr_fid,
    output logic [SEQ_W-1:0] wr_base,
    output logic [DNW-1:0]   wr_n,
    output logic             free_en,
    output logic [FW-1:0]    free_fid,
    output logic             call_overflow
);
    logic [SEQ_W-1:0] seq_q  [MAXD];
    logic [LCW-1:0]   live_q [MAXD];
    belt_op_e         op;
    logic [DNW-1:0]   n_eff;
    logic [LCW-1:0]   base_live;
    logic [LCW:0]     live_sum;
    logic [LCW-1:0]   new_live;

    // Clamp the lane count to the number of lanes.
    always_comb n_eff = (drop_n > DNW'(DP)) ? DNW'(DP) : drop_n;

    // Decode the operation; a call wins over a return.
    always_comb begin
        call_overflow = call_req && (depth == FW'(MAXD - 1));
        if (call_req)
            op = call_overflow ? OP_IDLE : OP_CALL;
        else if (ret_req)
            op = (depth == '0) ? OP_IDLE : OP_RET;
        else
            op = OP_DROP;
    end

    // Select the target frame and the sequence base for the lanes.
    always_comb begin
        case (op)
            OP_CALL: wr_fid = depth + FW'(1);
            OP_RET:  wr_fid = depth - FW'(1);
            default: wr_fid = depth;
        endcase
        wr_base   = (op == OP_CALL) ? '0 : seq_q[wr_fid];
        base_live = (op == OP_CALL) ? '0 : live_q[wr_fid];
        wr_n      = (op == OP_IDLE) ? '0 : n_eff;
        live_sum  = {1'b0, base_live} + (LCW+1)'(wr_n);
        new_live  = (live_sum > (LCW+1)'(BELT_LEN)) ? LCW'(BELT_LEN) : live_sum[LCW-1:0];
        free_en   = (op == OP_RET);
        free_fid  = depth;
        cur_seq   = seq_q[depth];
        cur_live  = live_q[depth];
    end

    // Update the depth and the target frame's counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            depth <= '0;
            for (int f = 0; f < MAXD; f++) begin
                seq_q[f]  <= '0;
                live_q[f] <= '0;
            end
        end else if (op != OP_IDLE) begin
            seq_q[wr_fid]  <= wr_base + SEQ_W'(wr_n);
            live_q[wr_fid] <= new_live;
            if (op == OP_CALL)     depth <= depth + FW'(1);
            else if (op == OP_RET) depth <= depth - FW'(1);
        end
    end

    AST_OVERFLOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        call_overflow |=> depth == $past(depth)); // R8
    AST_RET_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_req && !call_req && depth == '0) |=> depth == '0); // R9
    AST_CALL_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
        (call_req && !call_overflow) |=> depth == FW'($past(depth) + FW'(1))); // R6
endmodule

// File: rtl/belt_cell_array.sv
// Tagged cell storage. Frame f owns cells f*BELT_LEN .. f*BELT_LEN+BELT_LEN-1;
// a value with sequence number s lands in slot s mod BELT_LEN of its frame.
// Lane k of a write of n values gets sequence base+n-1-k, so lane 0 is newest.
// Assumes BELT_LEN and MAXD are powers of two and writes never hit the frame
// being freed in the same cycle.
module belt_cell_array #(
    parameter int BELT_LEN = 8,
    parameter int MAXD     = 4,
    parameter int DP       = 2,
    parameter int DW       = 64,
    parameter int SEQ_W    = 8,
    localparam int FW      = $clog2(MAXD),
    localparam int LW      = $clog2(BELT_LEN),
    localparam int NCELL   = MAXD * BELT_LEN,
    localparam int DNW     = $clog2(DP + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [FW-1:0]               wr_fid,
    input  logic [SEQ_W-1:0]            wr_base,
    input  logic [DNW-1:0]              wr_n,
    input  logic [DP*DW-1:0]            wr_data,
    input  logic                        free_en,
    input  logic [FW-1:0]               free_fid,
    output logic [NCELL-1:0]            c_valid,
    output logic [NCELL-1:0][FW-1:0]    c_fid,
    output logic [NCELL-1:0][SEQ_W-1:0] c_idx,
    output logic [NCELL-1:0][DW-1:0]    c_data
);
    logic [SEQ_W-1:0]  lane_idx  [DP];
    logic [FW+LW-1:0]  lane_slot [DP];
    logic [DP-1:0]     lane_act;

    for (genvar k = 0; k < DP; k++) begin : g_lane
        // Compute the tag and cell slot of lane k.
        always_comb begin
            lane_idx[k]  = wr_base + SEQ_W'(wr_n) - SEQ_W'(k + 1);
            lane_slot[k] = {wr_fid, lane_idx[k][LW-1:0]};
            lane_act[k]  = (DNW'(k) < wr_n);
        end
    end

    for (genvar c = 0; c < NCELL; c++) begin : g_cell
        // Tag update: free on return, then claim by an active lane.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                c_valid[c] <= 1'b0;
                c_fid[c]   <= '0;
                c_idx[c]   <= '0;
            end else begin
                if (free_en && c_fid[c] == free_fid) c_valid[c] <= 1'b0;
                for (int k = 0; k < DP; k++) begin
                    if (lane_act[k] && lane_slot[k] == (FW+LW)'(c)) begin
                        c_valid[c] <= 1'b1;
                        c_fid[c]   <= wr_fid;
                        c_idx[c]   <= lane_idx[k];
                    end
                end
            end
        end

        // Data capture for the claiming lane; data needs no reset.
        always_ff @(posedge clk) begin
            for (int k = 0; k < DP; k++)
                if (lane_act[k] && lane_slot[k] == (FW+LW)'(c))
                    c_data[c] <= wr_data[k*DW +: DW];
        end
    end

    // Checker state: the frame freed in the previous cycle.
    logic            chk_free;
    logic [FW-1:0]   chk_fid;
    logic [NCELL-1:0] chk_left;
    always_ff @(posedge clk) begin
        chk_free <= rst_n && free_en;
        chk_fid  <= free_fid;
    end
    always_comb
        for (int c = 0; c < NCELL; c++)
            chk_left[c] = c_valid[c] && (c_fid[c] == chk_fid);

    AST_FREE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        chk_free |-> chk_left == '0); // R7
endmodule

// File: rtl/belt_read_port.sv
// One read port: converts a belt position into the sequence number
// cur_seq-1-pos and selects the cell whose tag holds that number and the
// current frame. Positions at or past the live count read as invalid zero.
module belt_read_port #(
    parameter int BELT_LEN = 8,
    parameter int MAXD     = 4,
    parameter int DW       = 64,
    parameter int SEQ_W    = 8,
    localparam int FW      = $clog2(MAXD),
    localparam int PW      = $clog2(BELT_LEN),
    localparam int LCW     = $clog2(BELT_LEN + 1),
    localparam int NCELL   = MAXD * BELT_LEN
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [PW-1:0]               pos,
    input  logic [FW-1:0]               cur_fid,
    input  logic [SEQ_W-1:0]            cur_seq,
    input  logic [LCW-1:0]              cur_live,
    input  logic [NCELL-1:0]            c_valid,
    input  logic [NCELL-1:0][FW-1:0]    c_fid,
    input  logic [NCELL-1:0][SEQ_W-1:0] c_idx,
    input  logic [NCELL-1:0][DW-1:0]    c_data,
    output logic [DW-1:0]               data,
    output logic                        invalid
);
    logic [SEQ_W-1:0] want;
    logic [NCELL-1:0] match;

    // Tag search across all cells and one-hot OR selection.
    always_comb begin
        want    = cur_seq - SEQ_W'(pos) - SEQ_W'(1);
        invalid = (LCW'(pos) >= cur_live);
        data    = '0;
        for (int c = 0; c < NCELL; c++) begin
            match[c] = c_valid[c] && c_fid[c] == cur_fid && c_idx[c] == want;
            if (match[c] && !invalid) data = data | c_data[c];
        end
    end

    AST_ONE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
        !invalid |-> $countones(match) == 1); // R4
endmodule

// File: rtl/operand_belt.sv
// Operand belt top: frame controller, tagged cell array and READ_PORTS
// tag-matching read ports. Reads see the state before this cycle's writes.
// Assumes BELT_LEN and MAX_DEPTH are powers of two, MAX_DEPTH >= 2, and
// DROP_PORTS <= BELT_LEN.
module operand_belt #(
    parameter int DATA_W     = 64,
    parameter int BELT_LEN   = 8,
    parameter int MAX_DEPTH  = 4,
    parameter int DROP_PORTS = 2,
    parameter int READ_PORTS = 4,
    parameter int SEQ_W      = 8,
    localparam int FW        = $clog2(MAX_DEPTH),
    localparam int PW        = $clog2(BELT_LEN),
    localparam int LCW       = $clog2(BELT_LEN + 1),
    localparam int DNW       = $clog2(DROP_PORTS + 1),
    localparam int NCELL     = MAX_DEPTH * BELT_LEN
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [DNW-1:0]               drop_n,
    input  logic [DROP_PORTS*DATA_W-1:0] drop_data,
    input  logic                         call_req,
    input  logic                         ret_req,
    input  logic [READ_PORTS*PW-1:0]     rd_pos,
    output logic [READ_PORTS*DATA_W-1:0] rd_data,
    output logic [READ_PORTS-1:0]        rd_invalid,
    output logic [FW-1:0]                frame_depth,
    output logic                         call_overflow
);
    logic [SEQ_W-1:0]            cur_seq;
    logic [LCW-1:0]              cur_live;
    logic [FW-1:0]               wr_fid;
    logic [SEQ_W-1:0]            wr_base;
    logic [DNW-1:0]              wr_n;
    logic                        free_en;
    logic [FW-1:0]               free_fid;
    logic [NCELL-1:0]            c_valid;
    logic [NCELL-1:0][FW-1:0]    c_fid;
    logic [NCELL-1:0][SEQ_W-1:0] c_idx;
    logic [NCELL-1:0][DATA_W-1:0] c_data;

    belt_frame_ctrl #(
        .BELT_LEN(BELT_LEN), .MAXD(MAX_DEPTH), .DP(DROP_PORTS), .SEQ_W(SEQ_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .drop_n(drop_n),
        .call_req(call_req), .ret_req(ret_req),
        .depth(frame_depth), .cur_seq(cur_seq), .cur_live(cur_live),
        .wr_fid(wr_fid), .wr_base(wr_base), .wr_n(wr_n),
        .free_en(free_en), .free_fid(free_fid), .call_overflow(call_overflow)
    );

    belt_cell_array #(
        .BELT_LEN(BELT_LEN), .MAXD(MAX_DEPTH), .DP(DROP_PORTS),
        .DW(DATA_W), .SEQ_W(SEQ_W)
    ) u_cells (
        .clk(clk), .rst_n(rst_n), .wr_fid(wr_fid), .wr_base(wr_base),
        .wr_n(wr_n), .wr_data(drop_data), .free_en(free_en),
        .free_fid(free_fid), .c_valid(c_valid), .c_fid(c_fid),
        .c_idx(c_idx), .c_data(c_data)
    );

    for (genvar i = 0; i < READ_PORTS; i++) begin : g_rd
        belt_read_port #(
            .BELT_LEN(BELT_LEN), .MAXD(MAX_DEPTH), .DW(DATA_W), .SEQ_W(SEQ_W)
        ) u_port (
            .clk(clk), .rst_n(rst_n), .pos(rd_pos[i*PW +: PW]),
            .cur_fid(frame_depth), .cur_seq(cur_seq), .cur_live(cur_live),
            .c_valid(c_valid), .c_fid(c_fid), .c_idx(c_idx), .c_data(c_data),
            .data(rd_data[i*DATA_W +: DATA_W]), .invalid(rd_invalid[i])
        );
    end
endmodule

// File: tb/tb_operand_belt.sv
`timescale 1ns/1ps
module tb_operand_belt;
    localparam int L = 8, MD = 4, NP = 4;

    logic          clk = 0, rst_n = 0;
    logic [1:0]    drop_n = 0;
    logic [127:0]  drop_data = 0;
    logic          call_req = 0, ret_req = 0;
    logic [11:0]   rd_pos = 0;
    logic [255:0]  rd_data;
    logic [3:0]    rd_invalid;
    logic [1:0]    frame_depth;
    logic          call_overflow;

    int tests = 0, fails = 0;
    bit done = 0;

    // Reference model: each frame is a shift array, newest at index 0.
    logic [63:0] mdl [MD][L];
    int mlive [MD];
    int mdep;
    int rp [NP];

    operand_belt dut (
        .clk(clk), .rst_n(rst_n), .drop_n(drop_n), .drop_data(drop_data),
        .call_req(call_req), .ret_req(ret_req), .rd_pos(rd_pos),
        .rd_data(rd_data), .rd_invalid(rd_invalid),
        .frame_depth(frame_depth), .call_overflow(call_overflow)
    );

    always #10 clk = ~clk;

    function automatic logic [63:0] exp_data(int p);
        return (p < mlive[mdep]) ? mdl[mdep][p] : 64'd0;
    endfunction

    task automatic mpush(int f, logic [63:0] v);
        for (int j = L - 1; j > 0; j--) mdl[f][j] = mdl[f][j-1];
        mdl[f][0] = v;
        if (mlive[f] < L) mlive[f]++;
    endtask

    task automatic mdrop(int f, int n, logic [63:0] a0, logic [63:0] a1);
        if (n >= 2) mpush(f, a1);
        if (n >= 1) mpush(f, a0);
    endtask

    // One cycle: drive at negedge, compare reads and flags, update model.
    task automatic step(int n, logic [63:0] a0, logic [63:0] a1,
                        bit call, bit ret, string tag);
        @(negedge clk);
        drop_n = 2'(n); drop_data = {a1, a0};
        call_req = call; ret_req = ret;
        for (int i = 0; i < NP; i++) rd_pos[i*3 +: 3] = 3'(rp[i]);
        #2;
        for (int i = 0; i < NP; i++) begin
            logic [63:0] e;
            bit ei;
            e  = exp_data(rp[i]);
            ei = (rp[i] >= mlive[mdep]);
            tests++;
            if (rd_data[i*64 +: 64] !== e || rd_invalid[i] !== ei) begin
                fails++;
                $display("FAIL %s port%0d pos%0d: got %h inv %b, exp %h inv %b",
                         tag, i, rp[i], rd_data[i*64 +: 64], rd_invalid[i], e, ei);
            end
        end
        tests++;
        if (frame_depth !== 2'(mdep) || call_overflow !== (call && mdep == MD - 1)) begin
            fails++;
            $display("FAIL %s depth/ovf: got %0d %b, exp %0d %b", tag, frame_depth,
                     call_overflow, mdep, (call && mdep == MD - 1));
        end
        if (call) begin
            if (mdep < MD - 1) begin
                mlive[mdep+1] = 0;
                mdrop(mdep + 1, n, a0, a1);
                mdep++;
            end
        end else if (ret) begin
            if (mdep > 0) begin
                mdep--;
                mdrop(mdep, n, a0, a1);
            end
        end else begin
            mdrop(mdep, n, a0, a1);
        end
    endtask

    task automatic look(int p0, int p1, int p2, int p3, string tag);
        rp[0] = p0; rp[1] = p1; rp[2] = p2; rp[3] = p3;
        step(0, 64'd0, 64'd0, 0, 0, tag);
    endtask

    function automatic logic [63:0] rnd64();
        return {$urandom, $urandom};
    endfunction

    initial begin
        #(20 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        mdep = 0;
        for (int f = 0; f < MD; f++) mlive[f] = 0;
        rp = '{0, 1, 2, 7};
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;

        look(0, 1, 2, 7, "R1");
        look(3, 4, 5, 6, "R1");

        // Single writes and saturation past the belt length
        rp = '{0, 1, 2, 3};
        step(1, 64'hA0, 0, 0, 0, "R2");
        look(0, 1, 2, 3, "R2");
        for (int k = 1; k <= 9; k++) step(1, 64'hA0 + 64'(k), 0, 0, 0, "R2");
        look(0, 1, 2, 3, "R2");
        look(4, 5, 6, 7, "R2");

        // Dual-lane write ordering
        step(2, 64'hB0, 64'hB1, 0, 0, "R3");
        look(0, 1, 2, 3, "R3");

        // Nest up, including an empty-argument call
        step(2, 64'hC0, 64'hC1, 1, 0, "R6");
        look(0, 1, 2, 3, "R6");
        look(2, 3, 4, 7, "R4");
        step(1, 64'hD0, 0, 1, 0, "R6");
        step(0, 0, 0, 1, 0, "R6");
        look(0, 1, 0, 7, "R4");
        step(1, 64'hE0, 0, 0, 0, "R5");

        // Overflow at the top depth
        step(2, 64'hF0, 64'hF1, 1, 0, "R8");
        look(0, 1, 2, 3, "R8");

        // Unwind with return values
        step(1, 64'h110, 0, 0, 1, "R7");
        look(0, 1, 2, 3, "R7");
        step(2, 64'h120, 64'h121, 0, 1, "R7");
        look(0, 1, 2, 3, "R7");

        // Call and return together: call wins
        step(1, 64'h130, 0, 1, 1, "R10");
        look(0, 1, 2, 3, "R10");
        step(0, 0, 0, 0, 1, "R7");
        step(0, 0, 0, 0, 1, "R7");
        look(0, 1, 2, 3, "R7");

        // Re-call sees only its own argument
        step(1, 64'h140, 0, 1, 0, "R11");
        look(0, 1, 2, 3, "R11");
        step(0, 0, 0, 0, 1, "R7");

        // Return at the outermost frame is ignored
        step(2, 64'h150, 64'h151, 0, 1, "R9");
        look(0, 1, 2, 3, "R9");
        look(4, 5, 6, 7, "R9");

        // Random mix of writes, calls and returns
        for (int c = 0; c < 3000; c++) begin
            int r;
            r = $urandom_range(99, 0);
            for (int i = 0; i < NP; i++) rp[i] = $urandom_range(7, 0);
            step($urandom_range(2, 0), rnd64(), rnd64(), r < 12, r >= 12 && r < 24, "R5");
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule